// File: doc/BRIEF.md
# Transmit Dominant Time-Out Guard

This block watches the active-low transmit-data line on its way to a bus transmitter. A low level asks the transmitter to drive the bus dominant. If software or hardware upstream gets stuck and holds the line low, a dominant bus would block all traffic on the network. The guard counts how long the line has stayed low without a break. When that run grows past a parameterised limit, it removes the transmitter enable and forces the drive level recessive.

Recovery is stricter than a plain timer. After a trip, one return to high is not enough. The input must stay high for an unbroken minimum release time before the guard re-arms. Both times are parameters counted in clock cycles. While the guard is in the tripped state, a status output stays high. All outputs are registered.

Top module: `tx_dom_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `drv_en` = 1, `drv_lvl` = 1 and `tripped` = 0, whatever state the guard was in before reset.
- R2: While armed, `drv_lvl` shows the `txd_n` value sampled at the previous rising clock edge (0 = dominant, 1 = recessive).
- R3: A run of up to `DOM_LIMIT` consecutive low samples of `txd_n` does not trip the guard. One high sample clears the run count.
- R4: The (`DOM_LIMIT`+1)-th consecutive low sample trips the guard. After that edge, `drv_en` = 0.
- R5: While tripped, `drv_lvl` = 1 whatever `txd_n` is. The guard stays tripped for as long as `txd_n` stays low.
- R6: While tripped, the `REL_MIN`-th consecutive high sample of `txd_n` re-arms the guard. After that edge, `drv_en` = 1.
- R7: While tripped, a high run shorter than `REL_MIN` that is followed by a low sample leaves the guard tripped. The next release then needs a full `REL_MIN` high samples.
- R8: `tripped` is 1 exactly when `drv_en` is 0.
- R9: After a re-arm, the dominant count starts from zero. A fresh trip again needs `DOM_LIMIT`+1 consecutive low samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_n | input | 1 | Transmit data, 0 = dominant request |
| drv_en | output | 1 | Transmitter enable, registered |
| drv_lvl | output | 1 | Effective drive level toward the bus, registered |
| tripped | output | 1 | High while the guard is in the tripped state |

## Verification
The bench builds the guard with `DOM_LIMIT` = 8 and `REL_MIN` = 5, in place of the defaults of thousands and hundreds of cycles. With these values, a trip and a release each take only a few cycles, so each can be run many times. They also make the exact boundaries cheap to hit: a low run of exactly the limit, a run one cycle longer, and a high run one cycle short of the release time. A reset while tripped and a second trip after a re-arm also fit in a short run.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

  typedef enum logic {
    G_ARMED   = 1'b0,
    G_TRIPPED = 1'b1
  } guard_state_t;

endpackage

// File: rtl/tdg_run_counter.sv
// Saturating run-length counter with synchronous clear; hit flags the limit.
module tdg_run_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIMIT_W = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != LIMIT_W)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == LIMIT_W);
endmodule

// File: rtl/tdg_fsm.sv
// Armed / tripped state holder and counter control.
module tdg_fsm
  import tdg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         txd_n,
  input  logic         dom_hit,
  input  logic         rel_hit,
  output logic         dom_clr,
  output logic         dom_inc,
  output logic         rel_clr,
  output logic         rel_inc,
  output guard_state_t nxt
);
  guard_state_t state;

  always_comb begin
    nxt = state;
    unique case (state)
      G_ARMED:   if (!txd_n && dom_hit) nxt = G_TRIPPED;
      G_TRIPPED: if (txd_n && rel_hit)  nxt = G_ARMED;
      default:   nxt = G_ARMED;
    endcase
  end

  always_comb begin
    dom_clr = (state != G_ARMED) || txd_n;
    dom_inc = (state == G_ARMED) && !txd_n;
    rel_clr = (state != G_TRIPPED) || !txd_n;
    rel_inc = (state == G_TRIPPED) && txd_n;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= G_ARMED;
    else     state <= nxt;
  end
endmodule

// File: rtl/tdg_out_stage.sv
// Registered outputs; recessive is forced while tripped.
module tdg_out_stage
  import tdg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         txd_n,
  input  guard_state_t nxt,
  output logic         drv_en,
  output logic         drv_lvl,
  output logic         tripped
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en  <= 1'b1;
      drv_lvl <= 1'b1;
      tripped <= 1'b0;
    end else begin
      drv_en  <= (nxt == G_ARMED);
      drv_lvl <= (nxt == G_ARMED) ? txd_n : 1'b1;
      tripped <= (nxt == G_TRIPPED);
    end
  end
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard
  import tdg_pkg::*;
#(
  parameter int DOM_LIMIT = 4000,
  parameter int REL_MIN   = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_n,
  output logic drv_en,
  output logic drv_lvl,
  output logic tripped
);
  localparam int REL_LIMIT = (REL_MIN < 1) ? 0 : REL_MIN - 1;

  logic dom_hit, rel_hit;
  logic dom_clr, dom_inc, rel_clr, rel_inc;
  guard_state_t nxt;

  tdg_run_counter #(.LIMIT(DOM_LIMIT)) u_dom_cnt (
    .clk(clk), .rst(rst), .clr(dom_clr), .inc(dom_inc), .hit(dom_hit)
  );

  tdg_run_counter #(.LIMIT(REL_LIMIT)) u_rel_cnt (
    .clk(clk), .rst(rst), .clr(rel_clr), .inc(rel_inc), .hit(rel_hit)
  );

  tdg_fsm u_fsm (
    .clk(clk), .rst(rst), .txd_n(txd_n),
    .dom_hit(dom_hit), .rel_hit(rel_hit),
    .dom_clr(dom_clr), .dom_inc(dom_inc),
    .rel_clr(rel_clr), .rel_inc(rel_inc),
    .nxt(nxt)
  );

  tdg_out_stage u_out (
    .clk(clk), .rst(rst), .txd_n(txd_n), .nxt(nxt),
    .drv_en(drv_en), .drv_lvl(drv_lvl), .tripped(tripped)
  );
endmodule

// File: rtl/tdg_guard_checker.sv
module tdg_guard_checker #(
  parameter int DOM_LIMIT = 4000
) (
  input logic clk,
  input logic rst,
  input logic txd_n,
  input logic drv_en,
  input logic drv_lvl,
  input logic tripped
);
  localparam int RW = $clog2(DOM_LIMIT + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(DOM_LIMIT + 1);

  logic [RW-1:0] low_run;
  logic          was_rst;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst || txd_n) low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
  end

  assert_status_match_R8: assert property (@(posedge clk) disable iff (rst)
    tripped == !drv_en);

  assert_recessive_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> drv_lvl);

  assert_follow_input_R2: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && drv_en && $past(drv_en)) |-> (drv_lvl == $past(txd_n)));

  assert_trip_at_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && $fell(drv_en)) |-> ($past(low_run) == RW'(DOM_LIMIT)));

  assert_trip_on_low_R4: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && $fell(drv_en)) |-> !$past(txd_n));

  assert_rearm_on_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && $rose(drv_en)) |-> $past(txd_n));
endmodule

bind tx_dom_guard tdg_guard_checker #(.DOM_LIMIT(DOM_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .txd_n(txd_n),
  .drv_en(drv_en), .drv_lvl(drv_lvl), .tripped(tripped)
);

// File: tb/tb_tx_dom_guard.sv
module tb_tx_dom_guard;
  localparam int DL = 8;
  localparam int RM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd_n = 1'b1;
  logic drv_en, drv_lvl, tripped;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tx_dom_guard #(.DOM_LIMIT(DL), .REL_MIN(RM)) dut (
    .clk(clk), .rst(rst), .txd_n(txd_n),
    .drv_en(drv_en), .drv_lvl(drv_lvl), .tripped(tripped)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d cycles expected < 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    txd_n = v;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic en, input logic lvl);
    check(req, drv_en, en);
    check(req, drv_lvl, lvl);
    check({req, "/R8"}, tripped, !en);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    txd_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1", 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic trip_now();
    for (int i = 0; i < DL + 1; i++) step(1'b0);
  endtask

  task automatic t_follow();
    logic pat [6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    for (int i = 0; i < 6; i++) begin
      step(pat[i]);
      expect_out("R2", 1'b1, pat[i]);
    end
  endtask

  task automatic t_no_trip();
    for (int i = 0; i < DL; i++) begin
      step(1'b0);
      expect_out("R3", 1'b1, 1'b0);
    end
    step(1'b1);
    expect_out("R3", 1'b1, 1'b1);
    for (int i = 0; i < DL; i++) step(1'b0);
    expect_out("R3", 1'b1, 1'b0);
    step(1'b1);
  endtask

  task automatic t_trip_hold();
    for (int i = 0; i < DL; i++) step(1'b0);
    expect_out("R4", 1'b1, 1'b0);
    step(1'b0);
    expect_out("R4", 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      step(1'b0);
      expect_out("R5", 1'b0, 1'b1);
    end
  endtask

  task automatic t_short_release();
    for (int i = 0; i < RM - 1; i++) begin
      step(1'b1);
      expect_out("R7", 1'b0, 1'b1);
    end
    step(1'b0);
    expect_out("R7", 1'b0, 1'b1);
    for (int i = 0; i < RM - 1; i++) step(1'b1);
    expect_out("R7", 1'b0, 1'b1);
    step(1'b1);
    expect_out("R6", 1'b1, 1'b1);
  endtask

  task automatic t_rearm_fresh();
    for (int i = 0; i < DL; i++) step(1'b0);
    expect_out("R9", 1'b1, 1'b0);
    step(1'b1);
    trip_now();
    expect_out("R9", 1'b0, 1'b1);
    for (int i = 0; i < RM - 1; i++) step(1'b1);
    expect_out("R6", 1'b0, 1'b1);
    step(1'b1);
    expect_out("R6", 1'b1, 1'b1);
    step(1'b0);
    expect_out("R2", 1'b1, 1'b0);
  endtask

  task automatic t_reset_tripped();
    step(1'b1);
    trip_now();
    expect_out("R4", 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    txd_n = 1'b0;
    @(posedge clk);
    #1;
    expect_out("R1", 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    txd_n = 1'b1;
    @(posedge clk);
    #1;
    expect_out("R1", 1'b1, 1'b1);
  endtask

  initial begin
    do_reset();
    t_follow();
    t_no_trip();
    t_trip_hold();
    t_short_release();
    t_rearm_fresh();
    t_reset_tripped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule